// File: doc/BRIEF.md
# Tagged FIFO with Run-Length Expansion

This block is the data queue of an extended-capability parallel port. Each entry is nine bits wide: eight data bits and a marker bit. Ordinary host writes always store the marker high. A second kind of write, the command fill, stores the marker low. It stands in for the reverse channel that loads compressed data.

When the host reads, an entry with the marker high, or with data bit 7 high, comes back as plain data and leaves the queue. An entry with the marker low and bit 7 low is a repeat count n, held in bits 6:0. It is never handed to the host. Instead, the entry behind it is returned n+1 times in a row, and only after that is it released.

The queue reports full and empty. A write that arrives while the queue is full is dropped. A read that finds nothing to return repeats the last byte.

Top module: `ecp_rle_fifo`

## Requirements
- R1: After reset `empty` is 1, `full` is 0 and `rd_data` is 0x00.
- R2: The queue holds 16 entries: `full` is 0 after 15 accepted writes and becomes 1 after the 16th.
- R3: A write presented while `full` is 1 is discarded; the 16 stored bytes read back in order, and the dropped byte never appears.
- R4: A write with `wr_cmd`=0 stores the marker bit as 1, so such a byte is returned as plain data even when its bit 7 is 0 (for example 0x05).
- R5: A `wr_cmd`=1 entry with bit 7 = 1 is returned as plain data on one read and removed.
- R6: A `wr_cmd`=1 entry with bit 7 = 0 is a count n in bits 6:0. It is removed without being returned, and the following entry is returned on exactly n+1 reads before the next entry is reached.
- R7: A count of 0 returns the following entry once.
- R8: A read while `empty` is 1 returns the previous `rd_data` again and leaves `empty` at 1.
- R9: A read that finds a count at the head with no entry behind it is an underrun: the previous byte is repeated, nothing is removed, and the run proceeds normally once the data byte is written.
- R10: `rd_data` changes only in the cycle after a read strobe.
- R11: A read and a write in the same cycle both take effect.
- R12: `full` and `empty` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one entry per cycle |
| wr_cmd | input | 1 | 1 stores the marker bit low (command fill); 0 is a host write with the marker high |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Returned byte, registered, valid the cycle after `rd_en` |
| full | output | 1 | Queue holds 16 entries |
| empty | output | 1 | Queue holds no entries |

## Verification
The hardest state to reach from the ports is a count entry sitting at the head of the queue with its data byte not yet written. That state must stall without losing the count. The stimulus first drains the queue down to a lone command byte. It then reads, which should give an underrun, and only afterwards supplies the data byte, so that the resumed run can be counted. Runs with a count of 0, a plain byte whose bit 7 is low, and a full queue that takes an extra write complete the coverage of the expansion rules.

// File: rtl/ecp_rle_pkg.sv
package ecp_rle_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = BYTE_W - 1;

    typedef struct packed {
        logic              mark;
        logic [BYTE_W-1:0] data;
    } q_word_t;

    function automatic logic is_count(q_word_t w);
        return (w.mark == 1'b0) && (w.data[BYTE_W-1] == 1'b0);
    endfunction
endpackage

// File: rtl/ecp_rle_store.sv
module ecp_rle_store
    import ecp_rle_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  q_word_t                    push_word,
    input  logic [1:0]                 pop_num,
    output q_word_t                    head_word,
    output q_word_t                    next_word,
    output logic [$clog2(DEPTH):0]     level,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
    } ptr_t;

    ptr_t    st_q, st_d;
    q_word_t mem [DEPTH];
    logic    push_ok;

    always_comb begin
        full    = (st_q.wptr[AW] != st_q.rptr[AW]) &&
                  (st_q.wptr[AW-1:0] == st_q.rptr[AW-1:0]);
        empty   = (st_q.wptr == st_q.rptr);
        level   = st_q.wptr - st_q.rptr;
        push_ok = push && !full;
        st_d    = st_q;
        if (push_ok) begin
            st_d.wptr = st_q.wptr + PW'(1);
        end
        st_d.rptr = st_q.rptr + PW'(pop_num);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[st_q.wptr[AW-1:0]] <= push_word;
        end
    end

    logic [AW-1:0] nxt_idx;
    always_comb begin
        nxt_idx   = st_q.rptr[AW-1:0] + AW'(1);
        head_word = mem[st_q.rptr[AW-1:0]];
        next_word = mem[nxt_idx];
    end
endmodule

// File: rtl/ecp_rle_expander.sv
module ecp_rle_expander
    import ecp_rle_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  q_word_t           head_word,
    input  q_word_t           next_word,
    input  logic [LVL_W-1:0]  level,
    output logic [1:0]        pop_num,
    output logic [BYTE_W-1:0] out_byte
);
    typedef struct packed {
        logic              run_on;
        logic [CNT_W-1:0]  left;
        logic [BYTE_W-1:0] last;
    } exp_t;

    exp_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        pop_num = 2'd0;
        if (rd_en) begin
            if (st_q.run_on) begin
                if (level >= LVL_W'(1)) begin
                    st_d.last = head_word.data;
                    if (st_q.left == '0) begin
                        pop_num     = 2'd1;
                        st_d.run_on = 1'b0;
                    end else begin
                        st_d.left = st_q.left - CNT_W'(1);
                    end
                end
            end else if (level >= LVL_W'(1)) begin
                if (is_count(head_word)) begin
                    if (level >= LVL_W'(2)) begin
                        st_d.last = next_word.data;
                        if (head_word.data[CNT_W-1:0] == '0) begin
                            pop_num = 2'd2;
                        end else begin
                            pop_num     = 2'd1;
                            st_d.run_on = 1'b1;
                            st_d.left   = head_word.data[CNT_W-1:0] - CNT_W'(1);
                        end
                    end
                end else begin
                    st_d.last = head_word.data;
                    pop_num   = 2'd1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_byte = st_q.last;
endmodule

// File: rtl/ecp_rle_fifo.sv
module ecp_rle_fifo
    import ecp_rle_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_cmd,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic              full,
    output logic              empty
);
    localparam int LVL_W = $clog2(DEPTH) + 1;

    q_word_t           in_word, head_w, next_w;
    logic [LVL_W-1:0]  lvl;
    logic [1:0]        pops;

    always_comb begin
        in_word.mark = !wr_cmd;
        in_word.data = wr_data;
    end

    ecp_rle_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_word (in_word),
        .pop_num   (pops),
        .head_word (head_w),
        .next_word (next_w),
        .level     (lvl),
        .full      (full),
        .empty     (empty)
    );

    ecp_rle_expander #(.LVL_W(LVL_W)) u_exp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .head_word (head_w),
        .next_word (next_w),
        .level     (lvl),
        .pop_num   (pops),
        .out_byte  (rd_data)
    );
endmodule

// File: rtl/ecp_rle_fifo_chk.sv
module ecp_rle_fifo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       full,
    input logic       empty
);
    assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> full);

    assert_underrun_repeat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en) |=> (rd_data == $past(rd_data)));

    assert_underrun_stays_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_en) |=> empty);

    assert_hold_without_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

bind ecp_rle_fifo ecp_rle_fifo_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .full    (full),
    .empty   (empty)
);

// File: tb/sim_ecp_rle_fifo.sv
module sim_ecp_rle_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_cmd = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       full, empty;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t sb_q[$];
    logic rd_seen = 1'b0;

    always #4 clk = ~clk;

    ecp_rle_fifo u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .full(full), .empty(empty)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "scoreboard empty", int'(rd_data), 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(rd_data === e.val, e.tag, int'(rd_data), int'(e.val));
            end
        end
    end

    task automatic put(input logic cmd, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_cmd = cmd; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_cmd = 1'b0;
    endtask

    task automatic get(input logic [7:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        e.val = exp; e.tag = tag;
        sb_q.push_back(e);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [7:0] fill_val(int i);
        return 8'(i * 7 + 3);
    endfunction

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(empty === 1'b1, "R1 empty", int'(empty), 1);
        chk(full === 1'b0, "R1 full", int'(full), 0);
        chk(rd_data === 8'h00, "R1 rd_data", int'(rd_data), 0);

        // R8 underrun straight after reset
        get(8'h00, "R8 underrun after reset");
        chk(empty === 1'b1, "R8 empty kept", int'(empty), 1);

        // R4 host byte with bit7 low is data; R5 plain byte
        put(1'b0, 8'h05);
        put(1'b0, 8'hA3);
        get(8'h05, "R4 host byte with bit7 low");
        get(8'hA3, "R5 host byte");
        get(8'hA3, "R8 underrun repeats last");
        chk(empty === 1'b1, "R8 empty after drain", int'(empty), 1);

        // R5 command byte with bit7 high
        put(1'b1, 8'h83);
        get(8'h83, "R5 command byte bit7 high");

        // R6 count 2 -> three copies
        put(1'b1, 8'h02);
        put(1'b0, 8'h5A);
        put(1'b0, 8'h11);
        get(8'h5A, "R6 run copy 1");
        get(8'h5A, "R6 run copy 2");
        get(8'h5A, "R6 run copy 3");
        get(8'h11, "R6 entry after run");

        // R7 count 0 -> one copy
        put(1'b1, 8'h00);
        put(1'b0, 8'h77);
        put(1'b0, 8'h22);
        get(8'h77, "R7 run of one");
        get(8'h22, "R7 entry after run");

        // R9 count with no data byte behind it
        put(1'b1, 8'h01);
        get(8'h22, "R9 stalled count repeats last");
        chk(empty === 1'b0, "R9 count kept", int'(empty), 0);
        put(1'b0, 8'h44);
        get(8'h44, "R9 resumed run copy 1");
        get(8'h44, "R9 resumed run copy 2");
        chk(empty === 1'b1, "R9 drained", int'(empty), 1);

        // R2 capacity, R3 overflow drop
        for (int i = 0; i < 15; i++) put(1'b0, fill_val(i));
        chk(full === 1'b0, "R2 not full at 15", int'(full), 0);
        put(1'b0, fill_val(15));
        chk(full === 1'b1, "R2 full at 16", int'(full), 1);
        put(1'b0, 8'hEE);
        chk(full === 1'b1, "R3 still full", int'(full), 1);
        for (int i = 0; i < 16; i++) get(fill_val(i), "R3 ordered readback");
        get(fill_val(15), "R3 dropped byte absent");
        chk(empty === 1'b1, "R3 empty after readback", int'(empty), 1);

        // R10 output holds with no read
        repeat (4) @(negedge clk);
        chk(rd_data === fill_val(15), "R10 hold", int'(rd_data), int'(fill_val(15)));

        // R11 simultaneous read and write
        put(1'b0, 8'h66);
        begin
            exp_t e;
            @(negedge clk);
            e.val = 8'h66; e.tag = "R11 read during write";
            sb_q.push_back(e);
            rd_en = 1'b1; wr_en = 1'b1; wr_cmd = 1'b0; wr_data = 8'h67;
            @(negedge clk);
            rd_en = 1'b0; wr_en = 1'b0;
        end
        chk(empty === 1'b0, "R11 write taken", int'(empty), 0);
        get(8'h67, "R11 written byte");

        repeat (2) @(negedge clk);
        chk(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule